// File: doc/BRIEF.md
# Transmit Collision Status Tracker

This block runs next to a half-duplex Ethernet transmitter and follows one frame at a time. It counts the bytes of the current attempt, classifies every collision as early or late against a selectable byte window, counts collisions, and tells the transmitter with one-cycle pulses whether to try again or give up. When the frame ends normally, it records whether the frame was held back by carrier deferral. It can then watch the collision input for a fixed number of transmit-clock ticks to detect a missing heartbeat.

The transmitter pulses `frm_start` at the beginning of each frame. It strobes `byte_sent` for every byte of the current attempt and pulses `tx_done` when the last byte has gone out. The status outputs are registered. They are valid once `st_final` is high, and they stay valid until the next frame start.

Top module: `txcol_status_tracker`

## Requirements
- R1: After synchronous reset every output is 0: all status flags, `st_retry_cnt`, `retry_req`, `abort_req` and `st_final`.
- R2: A `frm_start` pulse clears every flag, the retry count and the byte count in the following cycle, and opens a new frame in the sending phase.
- R3: While sending, a rising edge on `col_in` is a collision. If it comes with fewer bytes sent in the current attempt than the window (56 when `cfg_win64`=0, 64 when `cfg_win64`=1), and the retry limit is not used up, `retry_req` pulses for one cycle in the next cycle. `st_retry_cnt` rises by one and the attempt's byte count restarts at zero.
- R4: A collision with at least the window's byte count sent sets `st_late`, pulses `abort_req` and raises `st_final`, all in the next cycle. It also raises the retry count by one.
- R5: An early collision that arrives when the retry count already equals `cfg_retry_lim` fails attempt number `cfg_retry_lim`+1. It sets `st_rlim`, pulses `abort_req` instead of `retry_req`, and raises `st_final`. The count saturates at 15.
- R6: On `tx_done` without a collision, `st_defer` is set if `defer_in` was high at any cycle of the frame. If the frame saw any collision, `st_defer` stays 0.
- R7: With `cfg_hb_en`=1 at `tx_done`, the block counts `txclk_tick` pulses. If 40 ticks pass with `col_in` low, `st_hb` and `st_final` rise right after the 40th tick and not earlier.
- R8: A high `col_in` inside the heartbeat window ends the window at once: `st_final` rises and `st_hb` stays 0.
- R9: With `cfg_hb_en`=0 at `tx_done`, `st_final` rises in the next cycle and `st_hb` is never set.
- R10: `st_final` is 0 during the whole sending phase and the heartbeat window. `retry_req` and `abort_req` never pulse in the same cycle.
- R11: Collisions after the frame is final, or before any frame is started, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win64 | input | 1 | Late-collision window: 0 = 56 bytes, 1 = 64 bytes |
| cfg_hb_en | input | 1 | Enable the heartbeat check after transmission |
| cfg_retry_lim | input | 4 | Retry limit; attempt limit+1 failing aborts |
| frm_start | input | 1 | Pulse at the start of a new frame |
| byte_sent | input | 1 | One byte of the current attempt sent |
| col_in | input | 1 | Collision input from the line |
| defer_in | input | 1 | Transmitter is deferring to carrier |
| tx_done | input | 1 | Pulse when the last byte of the frame has gone out |
| txclk_tick | input | 1 | One transmit serial clock period elapsed |
| st_defer | output | 1 | Frame was deferred and saw no collision |
| st_hb | output | 1 | Heartbeat missing after transmission |
| st_late | output | 1 | Late collision aborted the frame |
| st_rlim | output | 1 | Retry limit reached, frame abandoned |
| st_retry_cnt | output | 4 | Collisions seen in this frame |
| retry_req | output | 1 | One-cycle request to back off and resend |
| abort_req | output | 1 | One-cycle request to abandon the frame |
| st_final | output | 1 | Status flags are complete |

## Verification
A byte counter that drifts or fails to restart after a retry shows up at the next collision: `retry_req` and `abort_req` swap, and `st_late` rises, one cycle after the collision edge. A retry counter off by one moves the abort one collision earlier or later, which is visible in `st_retry_cnt` and `st_rlim` at that collision. A heartbeat timer off by one moves the rise of `st_final` by one tick, so the bench samples `st_final` both after the 39th tick and after the 40th.

// File: rtl/txcol_pkg.sv
package txcol_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_HB   = 2'd2,
    PH_DONE = 2'd3
  } txcol_phase_e;
endpackage

// File: rtl/txcol_win_cnt.sv
// Byte counter for one transmit attempt; saturates at the active window.
module txcol_win_cnt #(
  parameter int SHORT_WIN = 56,
  parameter int LONG_WIN  = 64,
  localparam int W = $clog2(LONG_WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic sel_long,
  output logic past_win
);
  logic [W-1:0] cnt;
  logic [W-1:0] limit;

  assign limit    = sel_long ? W'(LONG_WIN) : W'(SHORT_WIN);
  assign past_win = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && !past_win)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txcol_retry.sv
// Collision counter for one frame, saturating, with limit compare.
module txcol_retry #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] cnt,
  output logic          exhausted
);
  localparam logic [CW-1:0] MAXV = '1;

  assign exhausted = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != MAXV)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txcol_hb_mon.sv
// Counts transmit-clock ticks in the post-transmit heartbeat window.
module txcol_hb_mon #(
  parameter int HB_WIN = 40,
  localparam int TW = $clog2(HB_WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic tick,
  output logic expire
);
  logic [TW-1:0] ticks;

  assign expire = run && tick && (ticks == TW'(HB_WIN - 1));

  always_ff @(posedge clk) begin
    if (rst || start)
      ticks <= '0;
    else if (run && tick && !expire)
      ticks <= ticks + 1'b1;
  end
endmodule

// File: rtl/txcol_status_tracker.sv
module txcol_status_tracker
  import txcol_pkg::*;
#(
  parameter int SHORT_WIN = 56,
  parameter int LONG_WIN  = 64,
  parameter int HB_WIN    = 40,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_win64,
  input  logic          cfg_hb_en,
  input  logic [CW-1:0] cfg_retry_lim,
  input  logic          frm_start,
  input  logic          byte_sent,
  input  logic          col_in,
  input  logic          defer_in,
  input  logic          tx_done,
  input  logic          txclk_tick,
  output logic          st_defer,
  output logic          st_hb,
  output logic          st_late,
  output logic          st_rlim,
  output logic [CW-1:0] st_retry_cnt,
  output logic          retry_req,
  output logic          abort_req,
  output logic          st_final
);
  txcol_phase_e phase;
  logic col_q, seen_defer;
  logic coll_ev, past_win, exhausted, hb_expire, hb_start;

  assign coll_ev  = (phase == PH_SEND) && col_in && !col_q && !frm_start;
  assign hb_start = (phase == PH_SEND) && tx_done && !coll_ev && !frm_start;

  txcol_win_cnt #(.SHORT_WIN(SHORT_WIN), .LONG_WIN(LONG_WIN)) i_win (
    .clk(clk), .rst(rst),
    .clr(frm_start || (coll_ev && !past_win)),
    .en(byte_sent && phase == PH_SEND),
    .sel_long(cfg_win64),
    .past_win(past_win)
  );

  txcol_retry #(.CW(CW)) i_retry (
    .clk(clk), .rst(rst), .clr(frm_start), .inc(coll_ev),
    .lim(cfg_retry_lim), .cnt(st_retry_cnt), .exhausted(exhausted)
  );

  txcol_hb_mon #(.HB_WIN(HB_WIN)) i_hb (
    .clk(clk), .rst(rst), .start(hb_start),
    .run(phase == PH_HB), .tick(txclk_tick), .expire(hb_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      col_q      <= 1'b0;
      seen_defer <= 1'b0;
      st_defer   <= 1'b0;
      st_hb      <= 1'b0;
      st_late    <= 1'b0;
      st_rlim    <= 1'b0;
      st_final   <= 1'b0;
      retry_req  <= 1'b0;
      abort_req  <= 1'b0;
    end else begin
      col_q     <= col_in;
      retry_req <= 1'b0;
      abort_req <= 1'b0;
      if (frm_start) begin
        phase      <= PH_SEND;
        seen_defer <= 1'b0;
        st_defer   <= 1'b0;
        st_hb      <= 1'b0;
        st_late    <= 1'b0;
        st_rlim    <= 1'b0;
        st_final   <= 1'b0;
      end else begin
        unique case (phase)
          PH_SEND: begin
            if (defer_in) seen_defer <= 1'b1;
            if (coll_ev) begin
              if (past_win) begin
                st_late   <= 1'b1;
                abort_req <= 1'b1;
                st_final  <= 1'b1;
                phase     <= PH_DONE;
              end else if (exhausted) begin
                st_rlim   <= 1'b1;
                abort_req <= 1'b1;
                st_final  <= 1'b1;
                phase     <= PH_DONE;
              end else begin
                retry_req <= 1'b1;
              end
            end else if (tx_done) begin
              st_defer <= (seen_defer || defer_in) && (st_retry_cnt == '0);
              if (cfg_hb_en) begin
                phase <= PH_HB;
              end else begin
                st_final <= 1'b1;
                phase    <= PH_DONE;
              end
            end
          end
          PH_HB: begin
            if (col_in) begin
              st_final <= 1'b1;
              phase    <= PH_DONE;
            end else if (hb_expire) begin
              st_hb    <= 1'b1;
              st_final <= 1'b1;
              phase    <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txcol_status_chk.sv
module txcol_status_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          frm_start,
  input logic          st_hb,
  input logic          st_late,
  input logic          st_rlim,
  input logic [CW-1:0] st_retry_cnt,
  input logic          retry_req,
  input logic          abort_req,
  input logic          st_final
);
  // R3: each retry request follows exactly one new collision
  a_r3_retry_counts: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> st_retry_cnt == $past(st_retry_cnt) + 1'b1);

  // R4: a new late collision always comes with an abort
  a_r4_late_aborts: assert property (@(posedge clk) disable iff (rst)
    $rose(st_late) |-> (abort_req && st_final));

  // R5: the retry limit aborts and never asks for a retry
  a_r5_limit_aborts: assert property (@(posedge clk) disable iff (rst)
    $rose(st_rlim) |-> (abort_req && !retry_req && st_final));

  // R10: the two requests are exclusive, and a retry means not final
  a_r10_req_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retry_req, abort_req}));
  a_r10_retry_not_final: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> !st_final);

  // R7: the heartbeat flag appears only with final status
  a_r7_hb_final: assert property (@(posedge clk) disable iff (rst)
    st_hb |-> st_final);

  // R2: a frame start clears the final flag and the count
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> (!st_final && st_retry_cnt == '0));
endmodule

bind txcol_status_tracker txcol_status_chk #(.CW(CW)) i_chk (
  .clk(clk), .rst(rst), .frm_start(frm_start), .st_hb(st_hb),
  .st_late(st_late), .st_rlim(st_rlim), .st_retry_cnt(st_retry_cnt),
  .retry_req(retry_req), .abort_req(abort_req), .st_final(st_final)
);

// File: tb/test_txcol_status_tracker.sv
`timescale 1ns/1ps
module test_txcol_status_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_win64 = 1'b0, cfg_hb_en = 1'b0;
  logic [3:0] cfg_retry_lim = 4'd15;
  logic frm_start = 1'b0, byte_sent = 1'b0, col_in = 1'b0;
  logic defer_in = 1'b0, tx_done = 1'b0, txclk_tick = 1'b0;
  logic st_defer, st_hb, st_late, st_rlim, retry_req, abort_req, st_final;
  logic [3:0] st_retry_cnt;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  txcol_status_tracker i_txcol_status_tracker (.*);

  // {win64, bytes before collision (7 bits), late expected}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 7'd0,   1'b0}, {1'b0, 7'd55, 1'b0}, {1'b0, 7'd56, 1'b1},
    {1'b0, 7'd63,  1'b1}, {1'b1, 7'd55, 1'b0}, {1'b1, 7'd63, 1'b0},
    {1'b1, 7'd64,  1'b1}, {1'b1, 7'd100, 1'b1}
  };

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_frame();
    frm_start = 1'b1; step(); frm_start = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    byte_sent = 1'b1;
    for (int k = 0; k < n; k++) step();
    byte_sent = 1'b0;
  endtask

  task automatic collide();
    col_in = 1'b1; step(); col_in = 1'b0;
  endtask

  task automatic done();
    tx_done = 1'b1; step(); tx_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0; step();
    // R1 reset state
    chk({st_defer, st_hb, st_late, st_rlim, st_retry_cnt, retry_req, abort_req, st_final} == '0,
        "R1 reset", int'(st_retry_cnt) + int'(st_final), 0);

    // R11: collision before any frame changes nothing
    collide(); step();
    chk(st_retry_cnt == 0 && !retry_req && !abort_req, "R11 idle collision",
        int'(st_retry_cnt), 0);

    // R3/R4 table: window boundary for both settings
    foreach (VEC[i]) begin
      cfg_win64 = VEC[i][8];
      cfg_retry_lim = 4'd15;
      start_frame();
      chk(!st_final, "R10 final low while sending", int'(st_final), 0);
      send_bytes(int'(VEC[i][7:1]));
      collide();
      chk(st_late == VEC[i][0], "R4 late flag", int'(st_late), int'(VEC[i][0]));
      chk(retry_req == !VEC[i][0], "R3 retry request", int'(retry_req), int'(!VEC[i][0]));
      chk(abort_req == VEC[i][0], "R4 abort request", int'(abort_req), int'(VEC[i][0]));
      chk(st_retry_cnt == 1, "R3 count", int'(st_retry_cnt), 1);
      step();
      chk(!retry_req && !abort_req, "R10 pulse one cycle", int'(retry_req | abort_req), 0);
    end

    // R3: byte count restarts after a retry (55 + 55 stays early)
    cfg_win64 = 1'b0;
    start_frame();
    send_bytes(55); collide(); step();
    send_bytes(55); collide();
    chk(retry_req && !st_late, "R3 restart after retry", int'(retry_req), 1);

    // R2: new frame clears everything
    send_bytes(60); collide();
    chk(st_late && st_final, "R4 late after restart", int'(st_late), 1);
    start_frame();
    chk(!st_late && !st_final && st_retry_cnt == 0, "R2 clear on start",
        int'(st_retry_cnt), 0);

    // R5: limit 2 -> third collision aborts
    cfg_retry_lim = 4'd2;
    start_frame();
    collide(); chk(retry_req, "R5 first retry", int'(retry_req), 1); step();
    collide(); chk(retry_req, "R5 second retry", int'(retry_req), 1); step();
    collide();
    chk(st_rlim && abort_req && !retry_req && st_final, "R5 limit abort",
        int'(st_rlim), 1);
    chk(st_retry_cnt == 3, "R5 attempts", int'(st_retry_cnt), 3);
    // R11: collision after final ignored
    step(); collide(); step();
    chk(st_retry_cnt == 3 && !abort_req, "R11 final ignores collision",
        int'(st_retry_cnt), 3);

    // R5: limit 0 aborts on first collision
    cfg_retry_lim = 4'd0;
    start_frame(); collide();
    chk(st_rlim && abort_req, "R5 limit zero", int'(st_rlim), 1);

    // R6 / R9: deferred frame, no collision, heartbeat off
    cfg_retry_lim = 4'd15; cfg_hb_en = 1'b0;
    start_frame();
    defer_in = 1'b1; step(); defer_in = 1'b0;
    send_bytes(10);
    chk(!st_final, "R10 final low before done", int'(st_final), 0);
    done();
    chk(st_defer, "R6 defer set", int'(st_defer), 1);
    chk(st_final && !st_hb, "R9 final without heartbeat", int'(st_final), 1);

    // R6: defer with a collision -> no defer flag
    start_frame();
    defer_in = 1'b1; step(); defer_in = 1'b0;
    collide(); step();
    done();
    chk(!st_defer && st_final, "R6 defer cleared by collision", int'(st_defer), 0);

    // R7: heartbeat after 40 quiet ticks
    cfg_hb_en = 1'b1;
    start_frame(); send_bytes(5); done();
    txclk_tick = 1'b1;
    for (int k = 0; k < 39; k++) step();
    chk(!st_final && !st_hb, "R7 not final after 39 ticks", int'(st_final), 0);
    step(); txclk_tick = 1'b0;
    chk(st_hb && st_final, "R7 heartbeat after 40 ticks", int'(st_hb), 1);

    // R8: collision inside the window closes it early
    start_frame(); done();
    txclk_tick = 1'b1;
    for (int k = 0; k < 10; k++) step();
    txclk_tick = 1'b0;
    collide();
    chk(st_final && !st_hb, "R8 window closed by collision", int'(st_hb), 0);
    chk(st_retry_cnt == 0, "R8 count untouched", int'(st_retry_cnt), 0);

    // R1: reset mid-frame clears everything
    start_frame(); collide();
    rst = 1'b1; step(); rst = 1'b0; step();
    chk(st_retry_cnt == 0 && !retry_req && !st_final, "R1 reset mid-frame",
        int'(st_retry_cnt), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule